// File: doc/BRIEF.md
# Iterative Multiply-Divide Unit

This block performs integer multiplication and division over several clock cycles and keeps the outcome in a pair of result registers, called HI and LO. A one-cycle start pulse launches an operation. It carries a two-bit operation code and two operands. While the block works, the busy flag stays high. When it finishes, both result registers are written on the same clock edge. The registers are always visible on two read ports, which serve instructions that move HI or LO into the register file.

A multiply places the upper half of the double-width product in HI and the lower half in LO. A divide places the quotient in LO and the remainder in HI. Both kinds come in signed and unsigned forms. The core is unsigned and handles one operand bit per cycle. Multiply uses shift-and-add. Divide uses restoring subtraction. Signed forms run on operand magnitudes, and the signs are corrected when the results are committed.

Top module: `muldiv_unit`

## Requirements
- R1: Op code 2'b00 (signed multiply) leaves the full two's-complement product of the two operands with its upper WIDTH bits in HI and its lower WIDTH bits in LO.
- R2: Op code 2'b01 (unsigned multiply) leaves the full unsigned product in HI (upper half) and LO (lower half).
- R3: Op code 2'b10 (signed divide) leaves in LO the quotient truncated toward zero, and in HI the remainder, which carries the sign of the dividend.
- R4: Op code 2'b11 (unsigned divide) leaves the unsigned quotient in LO and the unsigned remainder in HI.
- R5: For either divide with a zero divisor, the operation completes normally with LO all ones and HI equal to the dividend operand.
- R6: A start pulse seen while idle raises busy on the next cycle. Busy then stays high for exactly WIDTH cycles (one setup edge plus WIDTH iteration edges in total). HI and LO take their new values on the edge where busy falls.
- R7: HI and LO keep their values on every edge except the one that finishes an operation.
- R8: A start pulse that arrives while busy is ignored. The running operation still produces its own result, and no second operation follows it.
- R9: After reset, busy is low and HI and LO are zero.
- R10: A signed divide of the most negative value by minus one wraps, giving LO equal to the most negative value and HI equal to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin an operation |
| op_i | input | 2 | Operation code: 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| a_i | input | WIDTH | Multiplicand or dividend |
| b_i | input | WIDTH | Multiplier or divisor |
| busy_o | output | 1 | High while an operation is in progress |
| hi_o | output | WIDTH | HI register: product upper half or remainder |
| lo_o | output | WIDTH | LO register: product lower half or quotient |

## Verification
The bench targets these corner cases:
- Mixed-sign divides and the most-negative operands. A design that negated the wrong result, or gave the remainder the divisor's sign, would return a quotient or remainder that is off in sign.
- Signed divide by zero with a negative dividend. A design that applied the sign fix to the quotient would return 1 where all ones is expected.
- The minimum-by-minus-one divide. A design that saturated instead of wrapping would fail here.
- A start pulse injected halfway through an operation. A design that relatched its operands or restarted would either replace the expected result or hold busy past the WIDTH-cycle window.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

   typedef enum logic [1:0] {
      OP_MULS = 2'b00,
      OP_MULU = 2'b01,
      OP_DIVS = 2'b10,
      OP_DIVU = 2'b11
   } md_op_e;

   function automatic logic op_is_div(input logic [1:0] op);
      return op[1];
   endfunction

   function automatic logic op_is_signed(input logic [1:0] op);
      return ~op[0];
   endfunction

endpackage

// File: rtl/muldiv_step.sv
// One iteration of the shared datapath: shift-add multiply or restoring divide.
module muldiv_step #(
   parameter int WIDTH = 32
) (
   input  logic             is_div,
   input  logic [WIDTH-1:0] acc_hi,
   input  logic [WIDTH-1:0] acc_lo,
   input  logic [WIDTH-1:0] opnd,
   output logic [WIDTH-1:0] nxt_hi,
   output logic [WIDTH-1:0] nxt_lo
);
   localparam int EW = WIDTH + 1;

   logic [EW-1:0] add_sum;
   logic [EW-1:0] shifted;
   logic [EW-1:0] diff;
   logic          fits;

   always_comb begin
      add_sum = {1'b0, acc_hi} + (acc_lo[0] ? {1'b0, opnd} : {EW{1'b0}});
      shifted = {acc_hi, acc_lo[WIDTH-1]};
      diff    = shifted - {1'b0, opnd};
      fits    = (shifted >= {1'b0, opnd});
      if (!is_div) begin
         nxt_hi = add_sum[WIDTH:1];
         nxt_lo = {add_sum[0], acc_lo[WIDTH-1:1]};
      end else if (fits) begin
         nxt_hi = diff[WIDTH-1:0];
         nxt_lo = {acc_lo[WIDTH-2:0], 1'b1};
      end else begin
         nxt_hi = shifted[WIDTH-1:0];
         nxt_lo = {acc_lo[WIDTH-2:0], 1'b0};
      end
   end
endmodule

// File: rtl/muldiv_fixup.sv
// Sign correction applied to the unsigned core result before commit.
module muldiv_fixup #(
   parameter int WIDTH = 32
) (
   input  logic             is_div,
   input  logic             neg_quo,
   input  logic             neg_rem,
   input  logic             div_zero,
   input  logic [WIDTH-1:0] raw_hi,
   input  logic [WIDTH-1:0] raw_lo,
   output logic [WIDTH-1:0] res_hi,
   output logic [WIDTH-1:0] res_lo
);
   localparam int DW = 2 * WIDTH;

   logic [DW-1:0] prod;

   always_comb begin
      prod = {raw_hi, raw_lo};
      if (neg_quo) prod = -prod;
      if (!is_div) begin
         res_hi = prod[DW-1:WIDTH];
         res_lo = prod[WIDTH-1:0];
      end else begin
         res_lo = (neg_quo && !div_zero) ? -raw_lo : raw_lo;
         res_hi = neg_rem ? -raw_hi : raw_hi;
      end
   end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
   import muldiv_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [1:0]       op_i,
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic             busy_o,
   output logic [WIDTH-1:0] hi_o,
   output logic [WIDTH-1:0] lo_o
);
   localparam int             CW   = $clog2(WIDTH);
   localparam logic [CW-1:0]  LAST = CW'(WIDTH - 1);

   generate
      if (WIDTH < 4 || (WIDTH & (WIDTH - 1)) != 0) begin : g_bad_width
         $error("muldiv_unit: WIDTH must be a power of two, at least 4");
      end
   endgenerate

   logic             busy_q;
   logic [CW-1:0]    cnt_q;
   logic             is_div_q, neg_quo_q, neg_rem_q, div_zero_q;
   logic [WIDTH-1:0] acc_hi_q, acc_lo_q, opnd_q;
   logic [WIDTH-1:0] hi_q, lo_q;

   logic             accept, finish;
   logic             in_signed, in_div, a_neg, b_neg;
   logic [WIDTH-1:0] a_mag, b_mag;
   logic [WIDTH-1:0] step_hi, step_lo, fin_hi, fin_lo;

   assign accept = start_i && !busy_q;
   assign finish = busy_q && (cnt_q == LAST);

   always_comb begin
      in_signed = op_is_signed(op_i);
      in_div    = op_is_div(op_i);
      a_neg     = in_signed && a_i[WIDTH-1];
      b_neg     = in_signed && b_i[WIDTH-1];
      a_mag     = a_neg ? -a_i : a_i;
      b_mag     = b_neg ? -b_i : b_i;
   end

   muldiv_step #(.WIDTH(WIDTH)) u_step (
      .is_div (is_div_q),
      .acc_hi (acc_hi_q),
      .acc_lo (acc_lo_q),
      .opnd   (opnd_q),
      .nxt_hi (step_hi),
      .nxt_lo (step_lo)
   );

   muldiv_fixup #(.WIDTH(WIDTH)) u_fix (
      .is_div   (is_div_q),
      .neg_quo  (neg_quo_q),
      .neg_rem  (neg_rem_q),
      .div_zero (div_zero_q),
      .raw_hi   (step_hi),
      .raw_lo   (step_lo),
      .res_hi   (fin_hi),
      .res_lo   (fin_lo)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q     <= 1'b0;
         cnt_q      <= '0;
         is_div_q   <= 1'b0;
         neg_quo_q  <= 1'b0;
         neg_rem_q  <= 1'b0;
         div_zero_q <= 1'b0;
         acc_hi_q   <= '0;
         acc_lo_q   <= '0;
         opnd_q     <= '0;
      end else if (accept) begin
         busy_q     <= 1'b1;
         cnt_q      <= '0;
         is_div_q   <= in_div;
         neg_quo_q  <= a_neg ^ b_neg;
         neg_rem_q  <= a_neg;
         div_zero_q <= in_div && (b_i == '0);
         acc_hi_q   <= '0;
         acc_lo_q   <= in_div ? a_mag : b_mag;
         opnd_q     <= in_div ? b_mag : a_mag;
      end else if (busy_q) begin
         acc_hi_q <= step_hi;
         acc_lo_q <= step_lo;
         cnt_q    <= cnt_q + 1'b1;
         if (finish) busy_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q <= '0;
         lo_q <= '0;
      end else if (finish) begin
         hi_q <= fin_hi;
         lo_q <= fin_lo;
      end
   end

   assign busy_o = busy_q;
   assign hi_o   = hi_q;
   assign lo_o   = lo_q;

   // R6: an accepted start always raises busy
   a_r6_start_raises_busy : assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> busy_o);

   // R6: iteration count begins at zero whenever busy rises
   a_r6_count_from_zero : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> (cnt_q == '0));

   // R6: final iteration ends the busy window
   a_r6_last_drops_busy : assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && cnt_q == LAST) |=> !busy_o);

   // R7: result registers only move on the finishing edge
   a_r7_hold_results : assert property (@(posedge clk) disable iff (!rst_n)
      !(busy_o && cnt_q == LAST) |=> ($stable(hi_o) && $stable(lo_o)));

   // R8: a start while busy does not restart the count
   a_r8_no_restart : assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && busy_o && cnt_q != LAST) |=> (busy_o && cnt_q != '0));

   // R5: divide by zero yields an all-ones quotient
   a_r5_div_zero_quo : assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy_o) && is_div_q && div_zero_q) |-> (lo_o == '1));

endmodule

// File: tb/muldiv_unit_tb_top.sv
`timescale 1ns/1ps
module muldiv_unit_tb_top;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start_i = 1'b0;
   logic [1:0]   op_i = 2'b00;
   logic [W-1:0] a_i = '0;
   logic [W-1:0] b_i = '0;
   logic         busy_o;
   logic [W-1:0] hi_o, lo_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   muldiv_unit #(.WIDTH(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
      .a_i(a_i), .b_i(b_i), .busy_o(busy_o), .hi_o(hi_o), .lo_o(lo_o)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] model(input logic [1:0] op, input logic [W-1:0] a,
                                         input logic [W-1:0] b);
      longint sa, sb, p, q, r;
      logic [63:0] u;
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      case (op)
         2'b00: begin p = sa * sb; return p; end
         2'b01: begin u = {32'b0, a} * {32'b0, b}; return u; end
         2'b10: begin
            if (b == '0) return {a, 32'hFFFF_FFFF};
            q = sa / sb; r = sa % sb;
            return {r[31:0], q[31:0]};
         end
         default: begin
            if (b == '0) return {a, 32'hFFFF_FFFF};
            return {a % b, a / b};
         end
      endcase
   endfunction

   task automatic run_op(input logic [1:0] op, input logic [W-1:0] a,
                         input logic [W-1:0] b, input bit inject);
      logic [63:0] exp, prev;
      bit ok_busy, ok_hold;
      string tag;
      exp = model(op, a, b);
      if (op[1] && b == '0) tag = "R5";
      else if (op == 2'b10 && a == 32'h8000_0000 && b == '1) tag = "R10";
      else if (op == 2'b00) tag = "R1";
      else if (op == 2'b01) tag = "R2";
      else if (op == 2'b10) tag = "R3";
      else tag = "R4";
      @(negedge clk);
      start_i = 1'b1; op_i = op; a_i = a; b_i = b;
      prev = {hi_o, lo_o};
      @(negedge clk);
      start_i = 1'b0; a_i = $urandom; b_i = $urandom;
      ok_busy = busy_o;
      ok_hold = ({hi_o, lo_o} === prev);
      for (int i = 0; i < W - 1; i++) begin
         if (inject && i == 9) begin
            start_i = 1'b1; op_i = op ^ 2'b10; a_i = $urandom; b_i = $urandom | 1;
         end
         @(negedge clk);
         start_i = 1'b0;
         ok_busy = ok_busy && busy_o;
         ok_hold = ok_hold && ({hi_o, lo_o} === prev);
      end
      chk("R6 busy high for the whole window", {63'b0, ok_busy}, 64'd1);
      chk("R7 results held while busy", {63'b0, ok_hold}, 64'd1);
      @(negedge clk);
      chk("R6 busy low after window", {63'b0, busy_o}, 64'd0);
      chk(tag, {hi_o, lo_o}, exp);
      if (inject) begin
         repeat (3) @(negedge clk);
         chk("R8 no second operation", {31'b0, busy_o, hi_o}, {32'b0, exp[63:32]});
         chk("R8 result kept", {32'b0, lo_o}, {32'b0, exp[31:0]});
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      chk("R9 reset busy", {63'b0, busy_o}, 64'd0);
      chk("R9 reset HI/LO", {hi_o, lo_o}, 64'd0);
      rst_n = 1'b1;

      run_op(2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
      run_op(2'b00, 32'h8000_0000, 32'h8000_0000, 1'b0);
      run_op(2'b00, 32'h8000_0000, 32'h7FFF_FFFF, 1'b1);
      run_op(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
      run_op(2'b01, 32'h8000_0000, 32'h0000_0002, 1'b1);
      run_op(2'b10, 32'hFFFF_FFF9, 32'd2, 1'b0);
      run_op(2'b10, 32'd7, 32'hFFFF_FFFE, 1'b0);
      run_op(2'b10, 32'hFFFF_FFF9, 32'hFFFF_FFFE, 1'b1);
      run_op(2'b10, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0);
      run_op(2'b10, 32'hFFFF_FF00, 32'd0, 1'b0);
      run_op(2'b11, 32'h1234_5678, 32'd0, 1'b0);
      run_op(2'b11, 32'hFFFF_FFFF, 32'd1, 1'b0);
      run_op(2'b11, 32'd5, 32'd9, 1'b1);

      for (int n = 0; n < 120; n++) begin
         logic [1:0] op;
         logic [W-1:0] a, b;
         op = 2'($urandom);
         a  = $urandom;
         b  = $urandom;
         if ((n % 5) == 0) b = b >> 20;
         run_op(op, a, b, (n % 7) == 3);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule